// File: doc/BRIEF.md
# Per-Voice Amplitude Envelope Generator

This block produces the 11-bit unsigned amplitude envelope of a single synthesizer voice. It advances once for each pulse on its sample tick input. On each tick it steps a free-running event counter. A rate gate compares that counter against a per-rate pattern to decide whether the envelope value may move on this tick. The envelope runs through four phases: Attack, Decay, Sustain and Release. Three 8-bit settings bytes choose between a shaped four-phase mode, a programmable ramp mode and a direct level mode.

Key-on, key-off, a global soft-reset flag and an end-of-sample-without-loop flag steer the phase. The outputs are the envelope, the phase, and a 7-bit coarse level for readback. Scaling audio samples by the envelope is done elsewhere.

Top module: `env_gen`

## Requirements
- R1: After reset the envelope is 0, the phase is Release (code 3; the phase codes are Attack 0, Decay 1, Sustain 2, Release 3), the coarse level is 0 and the event counter is 0.
- R2: On every tick the event counter is updated in three steps, in this order: if bits 2..0 are all zero it is XORed with 0x005; then, if bits 4..3 are both zero, it is XORed with 0x018; then 0x029 is subtracted, modulo 2^16.
- R3: The gate for rate code R is open when (counter AND mask(R)) XOR cmp(R) equals zero. The counter value used is the one before this tick's update. Code 0 is never open. Code 31 is always open. Code 30 is open when counter bit 5 is 0. Code 29 is open when counter bits 4..3 equal 01. Code 28 is open when counter bits 6..5 equal 00. Only an open gate lets a ramp step change the stored envelope.
- R4: A tick with soft-reset set forces envelope 0 and phase Release, whatever else is asserted. Otherwise, a tick with key-on forces envelope 0 and phase Attack, even if key-off is also set.
- R5: A tick with key-off, end-without-loop, or an existing Release phase (and no soft-reset or key-on) gives phase Release. On that tick the envelope drops by 8 and stops at 0, regardless of the settings bytes and the gate.
- R6: Direct mode is selected when ADSR1 bit 7 and GAIN bit 7 are both 0. In this mode each tick sets the envelope to GAIN[6:0] times 16.
- R7: Ramp mode is selected when ADSR1 bit 7 is 0 and GAIN bit 7 is 1. It steps at rate GAIN[4:0], and GAIN[6:5] picks the step. Mode 00 subtracts 32 and mode 10 adds 32. The stored result is clamped to 0..0x7FF.
- R8: The exponential step (ramp mode 01, and the Decay and Sustain phases of shaped mode) subtracts ((E-1)>>8)+1, computed with a signed shift, so E = 0 gives a step of 0.
- R9: Ramp mode 11 adds 32 while the previous tick's unclamped result is below 0x600, and adds 8 otherwise. That unclamped result is cleared by key-on and by soft-reset.
- R10: Shaped mode is selected when ADSR1 bit 7 is 1. In Attack with ADSR1[3:0] = 0xF it adds 1024 at rate 31. With any other attack field a it adds 32 at rate 2a+1.
- R11: On every tick that is not a Release tick, the phase moves from Attack to Decay when the unclamped result exceeds 0x7FF or is negative. This holds whether or not the gate is open and in every mode.
- R12: Decay steps at rate 2d+16 (d = ADSR1[6:4]) and Sustain at rate ADSR2[4:0], both exponentially. Decay moves to Sustain when the updated envelope bits 10..8 equal the sustain level. The sustain level is ADSR2[7:5] in shaped mode and GAIN[7:5] otherwise.
- R13: The coarse level always equals the envelope shifted right by 4. The envelope and the phase change only on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per output sample |
| key_on | input | 1 | Restart the envelope in Attack |
| key_off | input | 1 | Enter Release |
| soft_rst | input | 1 | Global mute: envelope to 0, Release |
| end_noloop | input | 1 | Sample ended without loop: enter Release |
| adsr1 | input | 8 | Shaped-mode select, decay and attack fields |
| adsr2 | input | 8 | Sustain level and sustain rate |
| gain | input | 8 | Direct level or ramp mode and rate |
| env_out | output | 11 | Current envelope |
| state_out | output | 2 | Current phase code |
| env_level | output | 7 | Envelope shifted right by 4 |

## Verification
A wrong phase register or a wrong stored unclamped value changes the slope chosen on the following tick, so it shows on the envelope pins one tick later. A fault in the event counter moves the ticks on which the gated ramp codes step. That appears as a misplaced step within a few ticks at codes 30, 29 and 28. Every tick is compared against a tick-by-tick reference, so the first wrong step, clamp or phase change is caught in the cycle after the tick that caused it.

// File: rtl/env_pkg.sv
package env_pkg;

   typedef enum logic [1:0] {
      PH_ATTACK  = 2'd0,
      PH_DECAY   = 2'd1,
      PH_SUSTAIN = 2'd2,
      PH_RELEASE = 2'd3
   } env_phase_e;

   typedef enum logic [2:0] {
      STEP_LIN_DEC,
      STEP_EXP_DEC,
      STEP_LIN_INC,
      STEP_BENT_INC,
      STEP_BIG_INC
   } env_step_e;

   function automatic logic [15:0] gate_mask(input logic [4:0] code);
      logic [15:0] m;
      case (code)
         5'd0:  m = 16'h0000;  5'd1:  m = 16'hFFE0;  5'd2:  m = 16'h3FF8;  5'd3:  m = 16'h1FE7;
         5'd4:  m = 16'h7FE0;  5'd5:  m = 16'h1FF8;  5'd6:  m = 16'h0FE7;  5'd7:  m = 16'h3FE0;
         5'd8:  m = 16'h0FF8;  5'd9:  m = 16'h07E7;  5'd10: m = 16'h1FE0;  5'd11: m = 16'h07F8;
         5'd12: m = 16'h03E7;  5'd13: m = 16'h0FE0;  5'd14: m = 16'h03F8;  5'd15: m = 16'h01E7;
         5'd16: m = 16'h07E0;  5'd17: m = 16'h01F8;  5'd18: m = 16'h00E7;  5'd19: m = 16'h03E0;
         5'd20: m = 16'h00F8;  5'd21: m = 16'h0067;  5'd22: m = 16'h01E0;  5'd23: m = 16'h0078;
         5'd24: m = 16'h0027;  5'd25: m = 16'h00E0;  5'd26: m = 16'h0038;  5'd27: m = 16'h0007;
         5'd28: m = 16'h0060;  5'd29: m = 16'h0018;  5'd30: m = 16'h0020;  default: m = 16'h0000;
      endcase
      return m;
   endfunction

   function automatic logic [15:0] gate_cmp(input logic [4:0] code);
      logic [15:0] c;
      case (code)
         5'd0:  c = 16'hFFFF;  5'd2:  c = 16'h3E08;  5'd3:  c = 16'h1D04;  5'd5:  c = 16'h1E08;
         5'd6:  c = 16'h0D04;  5'd8:  c = 16'h0E08;  5'd9:  c = 16'h0504;  5'd11: c = 16'h0608;
         5'd12: c = 16'h0104;  5'd14: c = 16'h0208;  5'd15: c = 16'h0104;
         5'd17, 5'd20, 5'd23, 5'd26, 5'd29: c = 16'h0008;
         5'd18, 5'd21, 5'd24, 5'd27:        c = 16'h0004;
         default: c = 16'h0000;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/env_tick_counter.sv
module env_tick_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] LOW_FLIP = CNT_W'(5);
   localparam logic [CNT_W-1:0] MID_FLIP = CNT_W'(24);
   localparam logic [CNT_W-1:0] DEC_STEP = CNT_W'(41);

   generate
      if (CNT_W != 16) begin : g_bad_width
         $error("env_tick_counter: CNT_W must be 16");
      end
   endgenerate

   logic [CNT_W-1:0] stage_a, stage_b, count_d;

   always_comb begin
      stage_a = (count[2:0] == 3'd0) ? (count ^ LOW_FLIP) : count;
      stage_b = (stage_a[4:3] == 2'd0) ? (stage_a ^ MID_FLIP) : stage_a;
      count_d = stage_b - DEC_STEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (tick) count <= count_d;
   end

   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count)) else $error("counter moved without tick"); // R2
   AST_CNT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> count != $past(count)) else $error("counter stuck on tick"); // R2
endmodule

// File: rtl/env_rate_gate.sv
module env_rate_gate #(
   parameter int CNT_W  = 16,
   parameter int RATE_W = 5
) (
   input  logic [CNT_W-1:0]  count,
   input  logic [RATE_W-1:0] rate,
   output logic              open
);
   import env_pkg::*;

   generate
      if (RATE_W != 5) begin : g_bad_rate
         $error("env_rate_gate: RATE_W must be 5");
      end
   endgenerate

   logic [15:0] masked;

   always_comb begin
      masked = count[15:0] & gate_mask(rate);
      open   = ((masked ^ gate_cmp(rate)) == 16'h0000);
   end
endmodule

// File: rtl/env_step_sel.sv
module env_step_sel #(
   parameter int ENV_W  = 11,
   parameter int REG_W  = 8,
   parameter int RATE_W = 5,
   localparam int RAW_W = ENV_W + 2
) (
   input  logic [ENV_W-1:0]        env,
   input  logic signed [RAW_W-1:0] raw_prev,
   input  env_pkg::env_phase_e     phase,
   input  logic [REG_W-1:0]        adsr1,
   input  logic [REG_W-1:0]        adsr2,
   input  logic [REG_W-1:0]        gain,
   output logic                    direct,
   output logic [ENV_W-1:0]        direct_val,
   output logic [RATE_W-1:0]       rate,
   output logic signed [RAW_W-1:0] delta,
   output logic [2:0]              sus_lvl
);
   import env_pkg::*;

   localparam logic signed [RAW_W-1:0] LIN_STEP  = RAW_W'(32);
   localparam logic signed [RAW_W-1:0] FINE_STEP = RAW_W'(8);
   localparam logic signed [RAW_W-1:0] BIG_STEP  = RAW_W'(1024);
   localparam logic signed [RAW_W-1:0] BENT_KNEE = RAW_W'(1536);
   localparam logic [RATE_W-1:0]       RATE_FULL = '1;

   generate
      if (REG_W != 8 || ENV_W != 11) begin : g_bad_fmt
         $error("env_step_sel: register and envelope widths are fixed");
      end
   endgenerate

   env_step_e              kind;
   logic                   shaped;
   logic signed [RAW_W-1:0] env_s, exp_term;

   always_comb begin
      shaped     = adsr1[REG_W-1];
      direct     = !shaped && !gain[REG_W-1];
      direct_val = ENV_W'({gain[REG_W-2:0], 4'b0000});
      sus_lvl    = shaped ? adsr2[REG_W-1 -: 3] : gain[REG_W-1 -: 3];
      rate       = gain[RATE_W-1:0];
      kind       = STEP_LIN_DEC;
      if (shaped) begin
         case (phase)
            PH_ATTACK: begin
               if (adsr1[3:0] == 4'hF) begin
                  rate = RATE_FULL;
                  kind = STEP_BIG_INC;
               end else begin
                  rate = {adsr1[3:0], 1'b1};
                  kind = STEP_LIN_INC;
               end
            end
            PH_DECAY: begin
               rate = {1'b1, adsr1[6:4], 1'b0};
               kind = STEP_EXP_DEC;
            end
            default: begin
               rate = adsr2[RATE_W-1:0];
               kind = STEP_EXP_DEC;
            end
         endcase
      end else begin
         case (gain[6:5])
            2'd0:    kind = STEP_LIN_DEC;
            2'd1:    kind = STEP_EXP_DEC;
            2'd2:    kind = STEP_LIN_INC;
            default: kind = STEP_BENT_INC;
         endcase
      end

      env_s    = $signed({2'b00, env});
      exp_term = ((env_s - RAW_W'(1)) >>> 8) + RAW_W'(1);
      case (kind)
         STEP_LIN_DEC:  delta = -LIN_STEP;
         STEP_EXP_DEC:  delta = -exp_term;
         STEP_LIN_INC:  delta = LIN_STEP;
         STEP_BENT_INC: delta = (raw_prev < BENT_KNEE) ? LIN_STEP : FINE_STEP;
         default:       delta = BIG_STEP;
      endcase
   end
endmodule

// File: rtl/env_gen.sv
module env_gen #(
   parameter int ENV_W  = 11,
   parameter int REG_W  = 8,
   parameter int CNT_W  = 16,
   parameter int RATE_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             key_on,
   input  logic             key_off,
   input  logic             soft_rst,
   input  logic             end_noloop,
   input  logic [REG_W-1:0] adsr1,
   input  logic [REG_W-1:0] adsr2,
   input  logic [REG_W-1:0] gain,
   output logic [ENV_W-1:0] env_out,
   output logic [1:0]       state_out,
   output logic [ENV_W-5:0] env_level
);
   import env_pkg::*;

   localparam int RAW_W = ENV_W + 2;
   localparam logic signed [RAW_W-1:0] ENV_MAX_S = RAW_W'((1 << ENV_W) - 1);
   localparam logic [ENV_W-1:0]        REL_STEP  = ENV_W'(8);

   logic [CNT_W-1:0]        count;
   logic                    gate_open, direct;
   logic [RATE_W-1:0]       rate;
   logic signed [RAW_W-1:0] delta, raw_sum, raw_q, raw_d;
   logic [ENV_W-1:0]        direct_val, env_q, env_d, env_clamped;
   logic [2:0]              sus_lvl;
   env_phase_e              phase_q, phase_d;
   logic                    rel_tick;

   env_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count));

   env_rate_gate #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_gate (
      .count(count), .rate(rate), .open(gate_open));

   env_step_sel #(.ENV_W(ENV_W), .REG_W(REG_W), .RATE_W(RATE_W)) u_step (
      .env(env_q), .raw_prev(raw_q), .phase(phase_q),
      .adsr1(adsr1), .adsr2(adsr2), .gain(gain),
      .direct(direct), .direct_val(direct_val), .rate(rate),
      .delta(delta), .sus_lvl(sus_lvl));

   always_comb begin
      raw_sum = $signed({2'b00, env_q}) + delta;
      if (raw_sum < 0)              env_clamped = '0;
      else if (raw_sum > ENV_MAX_S) env_clamped = ENV_MAX_S[ENV_W-1:0];
      else                          env_clamped = raw_sum[ENV_W-1:0];

      rel_tick = key_off || end_noloop || (phase_q == PH_RELEASE);
      env_d    = env_q;
      phase_d  = phase_q;
      raw_d    = raw_q;

      if (soft_rst) begin
         env_d   = '0;
         phase_d = PH_RELEASE;
         raw_d   = '0;
      end else if (key_on) begin
         env_d   = '0;
         phase_d = PH_ATTACK;
         raw_d   = '0;
      end else if (rel_tick) begin
         env_d   = (env_q > REL_STEP) ? (env_q - REL_STEP) : '0;
         phase_d = PH_RELEASE;
         raw_d   = $signed({2'b00, env_d});
      end else begin
         if (direct) begin
            env_d = direct_val;
            raw_d = $signed({2'b00, direct_val});
         end else begin
            raw_d = raw_sum;
            if (gate_open) env_d = env_clamped;
         end
         if (phase_q == PH_ATTACK) begin
            if (raw_d > ENV_MAX_S || raw_d < 0) phase_d = PH_DECAY;
         end else if (phase_q == PH_DECAY) begin
            if (env_d[ENV_W-1 -: 3] == sus_lvl) phase_d = PH_SUSTAIN;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         env_q   <= '0;
         phase_q <= PH_RELEASE;
         raw_q   <= '0;
      end else if (tick) begin
         env_q   <= env_d;
         phase_q <= phase_d;
         raw_q   <= raw_d;
      end
   end

   assign env_out   = env_q;
   assign state_out = phase_q;
   assign env_level = env_q[ENV_W-1:4];

   AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      tick && soft_rst |=> env_out == '0 && state_out == PH_RELEASE)
      else $error("soft reset not applied"); // R4
   AST_KEYON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !soft_rst && key_on |=> env_out == '0 && state_out == PH_ATTACK)
      else $error("key-on not applied"); // R4
   AST_REL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !soft_rst && !key_on && (key_off || end_noloop || state_out == PH_RELEASE)
      |=> state_out == PH_RELEASE &&
          env_out == (($past(env_out) > REL_STEP) ? ($past(env_out) - REL_STEP) : '0))
      else $error("release step wrong"); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(env_out) && $stable(state_out))
      else $error("envelope moved without tick"); // R13
   AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !soft_rst && !key_on && !rel_tick && !direct && rate == '0 |=> $stable(env_out))
      else $error("rate 0 changed envelope"); // R3
   AST_GATE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rate == '1 |-> gate_open)
      else $error("rate 31 gate closed"); // R3
endmodule

// File: tb/sim_env_gen.sv
module sim_env_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, key_on = 1'b0, key_off = 1'b0, soft_rst = 1'b0, end_noloop = 1'b0;
   logic [7:0] adsr1 = 8'h00, adsr2 = 8'h00, gain = 8'h00;
   logic [10:0] env_out;
   logic [1:0]  state_out;
   logic [6:0]  env_level;

   always #2 clk = ~clk;

   env_gen u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .key_on(key_on), .key_off(key_off),
      .soft_rst(soft_rst), .end_noloop(end_noloop), .adsr1(adsr1), .adsr2(adsr2),
      .gain(gain), .env_out(env_out), .state_out(state_out), .env_level(env_level));

   typedef struct {
      int    env;
      int    st;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_bad = 0;

   // reference state, built from the requirements
   int          m_env = 0, m_st = 3, m_raw = 0;
   logic [15:0] m_cnt = 16'h0000;

   function automatic bit ref_gate(input int code, input logic [15:0] c);
      case (code)
         0:  return 1'b0;
         31: return 1'b1;
         30: return c[5] == 1'b0;
         29: return c[4:3] == 2'b01;
         28: return c[6:5] == 2'b00;
         default: return 1'bx;
      endcase
   endfunction

   task automatic check(input int act, input int expv, input string tag, input string what);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic step(input bit kon, input bit koff, input bit srst, input bit eol,
                       input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] g,
                       input string tag);
      int rate, delta, r, sl;
      bit fire;
      logic [15:0] t;
      @(negedge clk);
      key_on = kon; key_off = koff; soft_rst = srst; end_noloop = eol;
      adsr1 = a1; adsr2 = a2; gain = g; tick = 1'b1;
      if (srst) begin
         m_env = 0; m_st = 3; m_raw = 0;
      end else if (kon) begin
         m_env = 0; m_st = 0; m_raw = 0;
      end else if (koff || eol || m_st == 3) begin
         m_env = (m_env > 8) ? m_env - 8 : 0; m_st = 3; m_raw = m_env;
      end else begin
         sl = a1[7] ? int'(a2[7:5]) : int'(g[7:5]);
         if (!a1[7] && !g[7]) begin
            m_env = int'(g[6:0]) * 16; m_raw = m_env;
         end else begin
            if (a1[7]) begin
               if (m_st == 0) begin
                  if (a1[3:0] == 4'hF) begin rate = 31; delta = 1024; end
                  else begin rate = 2 * int'(a1[3:0]) + 1; delta = 32; end
               end else begin
                  rate  = (m_st == 1) ? 2 * int'(a1[6:4]) + 16 : int'(a2[4:0]);
                  delta = -(((m_env - 1) >>> 8) + 1);
               end
            end else begin
               rate = int'(g[4:0]);
               case (g[6:5])
                  2'd0: delta = -32;
                  2'd1: delta = -(((m_env - 1) >>> 8) + 1);
                  2'd2: delta = 32;
                  default: delta = (m_raw < 'h600) ? 32 : 8;
               endcase
            end
            fire = ref_gate(rate, m_cnt);
            if (fire === 1'bx) begin
               n_bad++;
               $display("FAIL R3 bench uses unmodelled rate: actual %0d expected one of 0,28..31", rate);
               fire = 1'b0;
            end
            r = m_env + delta;
            if (fire) m_env = (r < 0) ? 0 : ((r > 'h7FF) ? 'h7FF : r);
            m_raw = r;
         end
         if (m_st == 0) begin
            if (m_raw > 'h7FF || m_raw < 0) m_st = 1;
         end else if (m_st == 1) begin
            if ((m_env >> 8) == sl) m_st = 2;
         end
      end
      t = m_cnt;
      if (t[2:0] == 3'd0) t = t ^ 16'h0005;
      if (t[4:3] == 2'd0) t = t ^ 16'h0018;
      m_cnt = t - 16'h0029;
      exp_q.push_back('{m_env, m_st, tag});
      @(negedge clk);
      tick = 1'b0; key_on = 1'b0; key_off = 1'b0; soft_rst = 1'b0; end_noloop = 1'b0;
   endtask

   task automatic run(input int n, input logic [7:0] a1, input logic [7:0] a2,
                      input logic [7:0] g, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, a1, a2, g, tag);
   endtask

   // monitor: compare after every tick
   initial begin
      forever begin
         @(posedge clk);
         if (tick) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R13 unexpected tick: actual 1 expected 0");
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(int'(env_out), e.env, e.tag, "envelope");
               check(int'(state_out), e.st, e.tag, "phase");
               check(int'(env_level), e.env >> 4, "R13", "coarse level");
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(int'(env_out), 0, "R1", "reset envelope");
      check(int'(state_out), 3, "R1", "reset phase");
      check(int'(env_level), 0, "R1", "reset level");
      run(3, 8'h00, 8'h00, 8'h45, "R5");                    // release holds at 0
      step(1, 0, 0, 0, 8'h00, 8'h00, 8'h45, "R4");
      run(2, 8'h00, 8'h00, 8'h45, "R6");                    // direct 0x450
      run(40, 8'h00, 8'h00, 8'h9F, "R7");                   // linear down, goes negative
      step(1, 0, 0, 0, 8'h00, 8'h00, 8'hDF, "R4");
      run(70, 8'h00, 8'h00, 8'hDF, "R11");                  // linear up to overflow
      run(2, 8'h00, 8'h00, 8'hFF, "R12");                   // sustain level from gain
      step(1, 0, 0, 0, 8'h00, 8'h00, 8'hFF, "R4");
      run(100, 8'h00, 8'h00, 8'hFF, "R9");                  // bent rise
      run(60, 8'h00, 8'h00, 8'hBF, "R8");                   // exponential fall
      run(10, 8'h00, 8'h00, 8'hC0, "R3");                   // rate 0 frozen
      step(1, 0, 0, 0, 8'h00, 8'h00, 8'hDE, "R4");
      run(40, 8'h00, 8'h00, 8'hDE, "R2");                   // rate 30 pattern
      run(40, 8'h00, 8'h00, 8'hDD, "R3");                   // rate 29 pattern
      run(40, 8'h00, 8'h00, 8'hDC, "R3");                   // rate 28 pattern
      step(1, 0, 0, 0, 8'hFF, 8'hBE, 8'h00, "R4");
      run(200, 8'hFF, 8'hBE, 8'h00, "R10");                 // fast attack, decay, sustain
      step(1, 1, 0, 0, 8'hEE, 8'h5C, 8'h00, "R4");          // key-on wins over key-off
      run(400, 8'hEE, 8'h5C, 8'h00, "R12");                 // slow attack, gated decay
      step(0, 1, 0, 0, 8'hEE, 8'h5C, 8'h00, "R5");
      run(300, 8'hEE, 8'h5C, 8'h00, "R5");
      step(1, 0, 0, 0, 8'h00, 8'h00, 8'h7F, "R4");
      run(2, 8'h00, 8'h00, 8'h7F, "R6");
      step(0, 0, 0, 1, 8'h00, 8'h00, 8'h7F, "R5");          // end without loop
      run(5, 8'h00, 8'h00, 8'h7F, "R5");
      step(1, 0, 0, 0, 8'h00, 8'h00, 8'h60, "R4");
      run(2, 8'h00, 8'h00, 8'h60, "R6");
      step(1, 1, 1, 0, 8'h00, 8'h00, 8'h60, "R4");          // soft reset wins
      run(2, 8'h00, 8'h00, 8'h60, "R5");
      repeat (4) @(negedge clk);
      check(exp_q.size(), 0, "R13", "pending results");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule